// File: doc/BRIEF.md
# Zero-Overhead Loop Controller

This block is the looping part of a program sequencer. A loop-start command records the loop's last address and a 4-bit exit condition code on a small loop stack. In the same cycle it saves the return point (the address after the command) on a deeper PC stack. Every cycle the block compares the current program address with the end address on top of the loop stack. On a match it steers the next fetch: back to the loop top while the externally evaluated exit condition is false, or on to the following address when it is true. On exit it pops both stacks. Jumping back to the loop top therefore costs no branch instruction.

A 14-bit down counter serves counted loops. Loading it saves the outer count on a count stack. Each check either decrements the count or, on its last iteration, raises the counter-expired flag and restores the saved outer count. Every stack has an empty flag and a sticky overflow flag. Condition evaluation and instruction decode live outside the block.

Top module: `zol_ctrl`

## Requirements
- R1: After a synchronous active-low reset all three stacks are empty, no overflow flag is set, the count is 0, the expired flag is 0 and the next-address select is sequential (0).
- R2: A loop-start command pushes {end address, condition code} onto the loop stack and the address pc_i+1 onto the PC stack. `loop_cond_o` shows the condition code of the top loop entry, or 0 when the loop stack is empty.
- R3: When the loop stack is empty or pc_i differs from the top end address, `nxt_sel_o` is 0 (sequential) and `nxt_pc_o` is pc_i+1.
- R4: When pc_i equals the top end address and `cond_true_i` is 0, `nxt_sel_o` is 1 (loop back) and `nxt_pc_o` is the top of the PC stack. Neither stack pops.
- R5: When pc_i equals the top end address and `cond_true_i` is 1, `nxt_sel_o` is 2 (exit) and `nxt_pc_o` is pc_i+1. The loop stack and the PC stack both pop at that clock edge.
- R6: A push to a full stack is discarded and sets that stack's overflow flag. The flag stays set until reset, whatever pops follow. Depths are 4 (loop), 16 (PC) and 4 (count).
- R7: A push and an effective pop in the same cycle replace the top entry and leave the depth unchanged.
- R8: A counter load sets the count to `cnt_data_i`, pushes the previous count onto the count stack and clears the expired flag.
- R9: A check with count other than 1 decrements the count and clears the expired flag. A check with count equal to 1 sets the expired flag and restores the count from the popped count stack, or 0 if that stack is empty. A loaded count of N therefore expires on the Nth check.
- R10: A load and a check in the same cycle act as a load only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pc_i | input | 14 | Address of the instruction now executing |
| do_push_i | input | 1 | Loop-start command |
| do_end_i | input | 14 | Last address of the new loop |
| do_cond_i | input | 4 | Exit condition code of the new loop |
| cond_true_i | input | 1 | Evaluated exit condition for the top loop |
| cnt_load_i | input | 1 | Load the down counter |
| cnt_data_i | input | 14 | Value to load into the counter |
| cnt_check_i | input | 1 | Check and decrement the counter |
| nxt_sel_o | output | 2 | Next-address source: 0 sequential, 1 loop back, 2 exit |
| nxt_pc_o | output | 14 | Next fetch address |
| loop_cond_o | output | 4 | Condition code of the top loop entry |
| count_o | output | 14 | Current counter value |
| ce_o | output | 1 | Counter-expired flag |
| loop_empty_o | output | 1 | Loop stack empty |
| loop_ovf_o | output | 1 | Loop stack overflowed (sticky) |
| pc_empty_o | output | 1 | PC stack empty |
| pc_ovf_o | output | 1 | PC stack overflowed (sticky) |
| cnt_empty_o | output | 1 | Count stack empty |
| cnt_ovf_o | output | 1 | Count stack overflowed (sticky) |

## Verification
The bench targets the following corner cases:
- An end-address match with a false condition. A design that pops here would lose the loop top after one pass.
- An exit in the same cycle as a new loop-start. A design that treats this as a plain pop or a plain push would leave the stack one level off.
- A fifth nested loop, where a design without a sticky flag, or one that overwrote the top, would let the overflow vanish or corrupt an outer loop.
- Nested counts that expire on the last check. A design with an off-by-one expiry or without the restore would run one iteration too many or return to the wrong outer count.

// File: rtl/zol_pkg.sv
// Package: shared encodings for the zero-overhead loop controller.
// Assumes: consumers cast nsel_e to a 2-bit port.
package zol_pkg;
    typedef enum logic [1:0] {
        NS_SEQ  = 2'd0,
        NS_TOP  = 2'd1,
        NS_EXIT = 2'd2
    } nsel_e;
endpackage

// File: rtl/zol_stack.sv
// Module: zol_stack - LIFO with empty flag and sticky overflow.
// Push to a full stack is dropped and sets ovf_o until reset.
// Push together with an effective pop rewrites the top entry.
// Assumes DEPTH >= 2; top_o is zero when empty.
module zol_stack #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic         pop_i,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] top_o,
    output logic         empty_o,
    output logic         ovf_o
);
    localparam int PW = $clog2(DEPTH + 1);
    localparam int IW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] fill;
    logic [PW-1:0] fill_m1;
    logic          do_pop;
    logic          full;

    assign fill_m1 = fill - PW'(1);
    assign empty_o = (fill == '0);
    assign full    = (fill == PW'(DEPTH));
    assign do_pop  = pop_i && !empty_o;
    assign top_o   = empty_o ? '0 : mem[fill_m1[IW-1:0]];

    // Fill level and sticky overflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill  <= '0;
            ovf_o <= 1'b0;
        end else if (do_pop && !push_i) begin
            fill <= fill_m1;
        end else if (push_i && !do_pop) begin
            if (full) ovf_o <= 1'b1;
            else      fill  <= fill + PW'(1);
        end
    end

    // Entry storage: rewrite top on push+pop, append on plain push.
    always_ff @(posedge clk) begin
        if (rst_n && push_i) begin
            if (do_pop)     mem[fill_m1[IW-1:0]] <= din_i;
            else if (!full) mem[fill[IW-1:0]]    <= din_i;
        end
    end
endmodule

// File: rtl/zol_downcnt.sv
// Module: zol_downcnt - loop down counter with a count stack.
// Load pushes the old count. A check at count 1 raises the expired
// flag and restores the outer count (0 if none). Any other check
// decrements. Load has priority over check.
module zol_downcnt #(
    parameter int CNTW   = 14,
    parameter int SDEPTH = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic [CNTW-1:0] data_i,
    input  logic            check_i,
    output logic [CNTW-1:0] count_o,
    output logic            ce_o,
    output logic            empty_o,
    output logic            ovf_o
);
    logic [CNTW-1:0] saved;
    logic            last;
    logic            pop_now;

    assign last    = (count_o == CNTW'(1));
    assign pop_now = check_i && !load_i && last;

    zol_stack #(.W(CNTW), .DEPTH(SDEPTH)) u_cstk (
        .clk    (clk),
        .rst_n  (rst_n),
        .push_i (load_i),
        .pop_i  (pop_now),
        .din_i  (count_o),
        .top_o  (saved),
        .empty_o(empty_o),
        .ovf_o  (ovf_o)
    );

    // Count register and expired flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_o <= '0;
            ce_o    <= 1'b0;
        end else if (load_i) begin
            count_o <= data_i;
            ce_o    <= 1'b0;
        end else if (check_i) begin
            ce_o    <= last;
            count_o <= last ? saved : count_o - CNTW'(1);
        end
    end
endmodule

// File: rtl/zol_ctrl.sv
// Module: zol_ctrl - zero-overhead loop controller (top).
// Compares pc_i against the top loop end address every cycle and picks
// the next fetch address. The exit condition is evaluated outside the
// block and returned on cond_true_i. Counter and stack flags are
// reported as is.
module zol_ctrl
    import zol_pkg::*;
#(
    parameter int AW         = 14,
    parameter int CW         = 4,
    parameter int CNTW       = 14,
    parameter int LOOP_DEPTH = 4,
    parameter int PC_DEPTH   = 16,
    parameter int CNT_DEPTH  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   pc_i,
    input  logic            do_push_i,
    input  logic [AW-1:0]   do_end_i,
    input  logic [CW-1:0]   do_cond_i,
    input  logic            cond_true_i,
    input  logic            cnt_load_i,
    input  logic [CNTW-1:0] cnt_data_i,
    input  logic            cnt_check_i,
    output logic [1:0]      nxt_sel_o,
    output logic [AW-1:0]   nxt_pc_o,
    output logic [CW-1:0]   loop_cond_o,
    output logic [CNTW-1:0] count_o,
    output logic            ce_o,
    output logic            loop_empty_o,
    output logic            loop_ovf_o,
    output logic            pc_empty_o,
    output logic            pc_ovf_o,
    output logic            cnt_empty_o,
    output logic            cnt_ovf_o
);
    localparam int LW = AW + CW;

    logic [LW-1:0] lp_top;
    logic [AW-1:0] pc_top;
    logic [AW-1:0] pc_inc;
    logic          at_end;
    logic          exit_now;
    nsel_e         sel;

    assign pc_inc      = pc_i + AW'(1);
    assign at_end      = !loop_empty_o && (pc_i == lp_top[LW-1:CW]);
    assign exit_now    = at_end && cond_true_i;
    assign loop_cond_o = lp_top[CW-1:0];
    assign nxt_sel_o   = sel;

    // Next-address source and value.
    always_comb begin
        if (!at_end) begin
            sel      = NS_SEQ;
            nxt_pc_o = pc_inc;
        end else if (cond_true_i) begin
            sel      = NS_EXIT;
            nxt_pc_o = pc_inc;
        end else begin
            sel      = NS_TOP;
            nxt_pc_o = pc_top;
        end
    end

    zol_stack #(.W(LW), .DEPTH(LOOP_DEPTH)) u_loop_stk (
        .clk    (clk),
        .rst_n  (rst_n),
        .push_i (do_push_i),
        .pop_i  (exit_now),
        .din_i  ({do_end_i, do_cond_i}),
        .top_o  (lp_top),
        .empty_o(loop_empty_o),
        .ovf_o  (loop_ovf_o)
    );

    zol_stack #(.W(AW), .DEPTH(PC_DEPTH)) u_pc_stk (
        .clk    (clk),
        .rst_n  (rst_n),
        .push_i (do_push_i),
        .pop_i  (exit_now),
        .din_i  (pc_inc),
        .top_o  (pc_top),
        .empty_o(pc_empty_o),
        .ovf_o  (pc_ovf_o)
    );

    zol_downcnt #(.CNTW(CNTW), .SDEPTH(CNT_DEPTH)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (cnt_load_i),
        .data_i (cnt_data_i),
        .check_i(cnt_check_i),
        .count_o(count_o),
        .ce_o   (ce_o),
        .empty_o(cnt_empty_o),
        .ovf_o  (cnt_ovf_o)
    );
endmodule

// File: rtl/zol_ctrl_chk.sv
// Module: zol_ctrl_chk - temporal properties of zol_ctrl, bound to the top.
module zol_ctrl_chk #(
    parameter int AW   = 14,
    parameter int CW   = 4,
    parameter int CNTW = 14
) (
    input logic            clk,
    input logic            rst_n,
    input logic [AW-1:0]   pc_i,
    input logic            do_push_i,
    input logic            cond_true_i,
    input logic            cnt_load_i,
    input logic [CNTW-1:0] cnt_data_i,
    input logic            cnt_check_i,
    input logic [1:0]      nxt_sel_o,
    input logic [AW-1:0]   nxt_pc_o,
    input logic [CW-1:0]   loop_cond_o,
    input logic [CNTW-1:0] count_o,
    input logic            ce_o,
    input logic            loop_empty_o,
    input logic            loop_ovf_o,
    input logic            pc_ovf_o,
    input logic            cnt_ovf_o
);
    assert_seq_when_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        loop_empty_o |-> (nxt_sel_o == 2'd0 && nxt_pc_o == AW'(pc_i + AW'(1))));

    assert_exit_next_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (nxt_sel_o == 2'd2) |-> (cond_true_i && nxt_pc_o == AW'(pc_i + AW'(1))));

    assert_top_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (nxt_sel_o == 2'd1 && !do_push_i) |=>
            (!loop_empty_o && loop_cond_o == $past(loop_cond_o)));

    assert_no_overflow_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_ovf_o || pc_ovf_o || cnt_ovf_o) |=>
            ((loop_ovf_o || !$past(loop_ovf_o)) && (pc_ovf_o || !$past(pc_ovf_o))
             && (cnt_ovf_o || !$past(cnt_ovf_o))));

    assert_load_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_load_i |=> (count_o == $past(cnt_data_i) && !ce_o));

    assert_expire_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_check_i && !cnt_load_i && count_o == CNTW'(1)) |=> ce_o);

    assert_decrement_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_check_i && !cnt_load_i && count_o != CNTW'(1)) |=>
            (!ce_o && count_o == CNTW'($past(count_o) - CNTW'(1))));
endmodule

bind zol_ctrl zol_ctrl_chk #(.AW(AW), .CW(CW), .CNTW(CNTW)) u_chk (
    .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .do_push_i(do_push_i),
    .cond_true_i(cond_true_i), .cnt_load_i(cnt_load_i), .cnt_data_i(cnt_data_i),
    .cnt_check_i(cnt_check_i), .nxt_sel_o(nxt_sel_o), .nxt_pc_o(nxt_pc_o),
    .loop_cond_o(loop_cond_o), .count_o(count_o), .ce_o(ce_o),
    .loop_empty_o(loop_empty_o), .loop_ovf_o(loop_ovf_o), .pc_ovf_o(pc_ovf_o),
    .cnt_ovf_o(cnt_ovf_o)
);

// File: tb/zol_ctrl_bench.sv
// Bench for zol_ctrl: directed corners plus seeded random traffic,
// each cycle compared against a behavioural model kept in the bench.
module zol_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] pc_i = '0;
    logic        do_push_i = 1'b0;
    logic [13:0] do_end_i = '0;
    logic [3:0]  do_cond_i = '0;
    logic        cond_true_i = 1'b0;
    logic        cnt_load_i = 1'b0;
    logic [13:0] cnt_data_i = '0;
    logic        cnt_check_i = 1'b0;
    logic [1:0]  nxt_sel_o;
    logic [13:0] nxt_pc_o;
    logic [3:0]  loop_cond_o;
    logic [13:0] count_o;
    logic        ce_o;
    logic        loop_empty_o, loop_ovf_o, pc_empty_o, pc_ovf_o, cnt_empty_o, cnt_ovf_o;

    zol_ctrl u_zol_ctrl (.*);

    always #10 clk = ~clk;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    // Model state: 0 loop stack, 1 PC stack, 2 count stack.
    logic [17:0] ms [3][16];
    int          md [3];
    bit          mo [3];
    int          lim [3] = '{4, 16, 4};
    logic [13:0] mcnt;
    bit          mce;
    string       ctag;

    task automatic chk(string tag, string what, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic mop(int k, bit push, bit pop, logic [17:0] d);
        if (pop && md[k] > 0 && push) ms[k][md[k]-1] = d;
        else if (pop && md[k] > 0) md[k]--;
        else if (push) begin
            if (md[k] == lim[k]) mo[k] = 1'b1;
            else begin ms[k][md[k]] = d; md[k]++; end
        end
    endtask

    function automatic logic [17:0] mtop(int k);
        return (md[k] > 0) ? ms[k][md[k]-1] : 18'd0;
    endfunction

    task automatic mreset();
        for (int k = 0; k < 3; k++) begin md[k] = 0; mo[k] = 1'b0; end
        mcnt = '0; mce = 1'b0; ctag = "R1";
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; do_push_i = 0; cnt_load_i = 0; cnt_check_i = 0; cond_true_i = 0;
        repeat (2) @(negedge clk);
        mreset();
        rst_n = 1'b1;
    endtask

    // One cycle: drive, compare combinational and state outputs, advance model.
    task automatic step(logic [13:0] pc, bit dop, logic [13:0] e, logic [3:0] c,
                        bit ct, bit ld, logic [13:0] dat, bit ck);
        logic [17:0] lt;
        bit          at_end;
        int          esel;
        logic [13:0] epc, inc, sv;
        string       stag;
        @(negedge clk);
        pc_i = pc; do_push_i = dop; do_end_i = e; do_cond_i = c; cond_true_i = ct;
        cnt_load_i = ld; cnt_data_i = dat; cnt_check_i = ck;
        #1;
        lt = mtop(0);
        inc = pc + 14'd1;
        at_end = (md[0] > 0) && (pc == lt[17:4]);
        if (!at_end) begin esel = 0; epc = inc; stag = "R3"; end
        else if (ct) begin esel = 2; epc = inc; stag = "R5"; end
        else begin esel = 1; epc = mtop(1)[13:0]; stag = "R4"; end
        chk(stag, "nxt_sel", nxt_sel_o, esel);
        chk(stag, "nxt_pc", nxt_pc_o, epc);
        chk("R2", "loop_cond", loop_cond_o, lt[3:0]);
        chk("R2", "loop_empty", loop_empty_o, md[0] == 0);
        chk("R2", "pc_empty", pc_empty_o, md[1] == 0);
        chk("R6", "loop_ovf", loop_ovf_o, mo[0]);
        chk("R6", "pc_ovf", pc_ovf_o, mo[1]);
        chk("R6", "cnt_ovf", cnt_ovf_o, mo[2]);
        chk("R8", "cnt_empty", cnt_empty_o, md[2] == 0);
        chk(ctag, "count", count_o, mcnt);
        chk(ctag, "ce", ce_o, mce);
        // Advance model to post-edge state.
        mop(0, dop, at_end && ct, {e, c});
        mop(1, dop, at_end && ct, {4'd0, inc});
        if (ld) begin
            mop(2, 1'b1, 1'b0, {4'd0, mcnt});
            mcnt = dat; mce = 1'b0;
            ctag = ck ? "R10" : "R8";
        end else if (ck) begin
            ctag = "R9";
            if (mcnt == 14'd1) begin
                sv = mtop(2)[13:0];
                mop(2, 1'b0, 1'b1, 18'd0);
                mcnt = sv; mce = 1'b1;
            end else begin
                mcnt = mcnt - 14'd1; mce = 1'b0;
            end
        end
    endtask

    task automatic idle(logic [13:0] pc);
        step(pc, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        void'($urandom(32'h5EED_0A1C));
        do_reset();
        @(negedge clk); #1;
        chk("R1", "reset sel", nxt_sel_o, 0);
        chk("R1", "reset loop_empty", loop_empty_o, 1);
        chk("R1", "reset ovf", loop_ovf_o | pc_ovf_o | cnt_ovf_o, 0);
        chk("R1", "reset count", count_o, 0);
        chk("R1", "reset ce", ce_o, 0);

        // R2/R4/R5: one loop, two passes back, then exit.
        step(14'h005, 1, 14'h010, 4'h3, 0, 0, 0, 0);
        idle(14'h006);
        step(14'h010, 0, 0, 0, 0, 0, 0, 0);
        step(14'h010, 0, 0, 0, 0, 0, 0, 0);
        step(14'h010, 0, 0, 0, 1, 0, 0, 0);
        idle(14'h011);

        // R7: exit and new loop-start in the same cycle.
        step(14'h018, 1, 14'h020, 4'h1, 0, 0, 0, 0);
        step(14'h020, 1, 14'h030, 4'h7, 1, 0, 0, 0);
        @(posedge clk); #2;
        chk("R7", "replaced cond", loop_cond_o, 4'h7);
        chk("R7", "depth kept", loop_empty_o, 0);
        step(14'h030, 0, 0, 0, 1, 0, 0, 0);
        idle(14'h031);
        chk("R7", "empty after one exit", loop_empty_o, 1);

        // R6: five nested loop-starts overflow the 4-deep loop stack.
        do_reset();
        for (int i = 0; i < 5; i++)
            step(14'(16 * i), 1, 14'(14'h100 + 4 * i), 4'(i), 0, 0, 0, 0);
        idle(14'h3FF);
        chk("R6", "loop ovf set", loop_ovf_o, 1);
        step(14'h10C, 0, 0, 0, 1, 0, 0, 0);
        for (int i = 0; i < 3; i++) step(14'(14'h108 - 4 * i), 0, 0, 0, 1, 0, 0, 0);
        idle(14'h000);
        chk("R6", "ovf sticky after pops", loop_ovf_o, 1);

        // R8/R9/R10: nested counts and load-vs-check priority.
        do_reset();
        step(0, 0, 0, 0, 0, 1, 14'd3, 0);
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 0, 1, 14'd5, 0);
        step(0, 0, 0, 0, 0, 1, 14'd2, 0);
        step(0, 0, 0, 0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 0, 0, 0, 1);
        idle(0);
        chk("R9", "outer count restored", count_o, 5);
        step(0, 0, 0, 0, 0, 1, 14'd9, 1);
        idle(0);
        chk("R10", "load wins", count_o, 9);
        for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 0, 1, 14'(i + 1), 0);
        idle(0);

        // Random traffic.
        do_reset();
        for (int n = 0; n < 4000; n++) begin
            logic [13:0] ends [4];
            logic [13:0] pc;
            ends = '{14'h040, 14'h080, 14'h0C0, 14'h100};
            pc = ($urandom % 2) ? ends[$urandom % 4] : 14'($urandom);
            step(pc, ($urandom % 6) == 0, ends[$urandom % 4], 4'($urandom),
                 ($urandom % 3) == 0, ($urandom % 7) == 0, 14'($urandom % 4 + 1),
                 ($urandom % 2) == 0);
            if (n % 1000 == 999) do_reset();
        end
        idle(0);
        done = 1'b1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end
endmodule